// File: doc/BRIEF.md
# Forward Slice Collector

This unit sits beside the retire stage of a core that speculates on load values. When a load whose value was predicted retires, the unit opens a new slice for it and follows every later retiring instruction that consumes that value, directly or through other instructions. Dependences are followed through registers, using a per-register slice mask, and through memory, using a small table of addresses stored to by slice instructions. Each captured instruction is written to a shared slice buffer in retire order. The entry holds the opcode, the register identifiers, the access address and the value of every source operand that came from outside the slice.

Each slice has a descriptor with an active flag, an entry count, a lost flag and a group mask. When one instruction draws on two slices, the entry carries both slice bits and both descriptors take the union as their group. A replay engine can then read every entry that touches the group, in buffer order, and that order is program order. If the buffer is full or the address table cannot take a new address, the slice is marked lost so that the core falls back to an ordinary rollback. Confirming a prediction as correct releases the slice. Once no slice is active, the buffer write index goes back to zero.

Top module: `slice_collector`

## Requirements
- R1: A retiring load with the seed flag set, while a slice id is free, takes the lowest free id. One cycle later `seed_ok` is 1 and `seed_sid` gives that id, the slice becomes active and its group is its own bit, and the load is stored as an entry with only that bit in its mask. If no id is free, `seed_ok` is 0 and no slice opens.
- R2: A retiring instruction is captured when any enabled source register carries a slice mask. Its entry mask is the OR of those masks, and its destination register takes that mask.
- R3: An instruction that writes a destination register and is not captured clears that register's mask, so later readers of that register are not captured.
- R4: A captured store records its address in the address table. A later load to the same address is captured with the store's slice mask. A load to a different address is not captured.
- R5: For every captured entry, `rd_live0`/`rd_live1` is 1 exactly for an enabled source whose register mask was zero, and `rd_val0`/`rd_val1` then holds that operand value.
- R6: Captured instructions are written at consecutive indices in retire order. `buf_fill` is the next index, and each descriptor count is the number of entries that carry that slice's bit.
- R7: A captured instruction whose mask has more than one bit keeps all of those bits in its entry, and every slice in the mask ORs the mask into its group.
- R8: When an instruction would be captured while `buf_fill` equals the depth, it is not written, `buf_fill` stays the same, and every slice in its mask is marked lost. A lost slice is always active.
- R9: When a captured store needs a new address-table entry and none is free, every slice in its mask is marked lost. The entry is still written if the buffer has room.
- R10: `conf_valid` with `conf_sid` makes that slice inactive on the next cycle, with count, lost flag and group cleared. Its bit is removed from all register masks, address-table entries and buffer entries. When no slice stays active, `buf_fill` returns to 0.
- R11: The read port shows the entry at `rd_idx` one cycle after `rd_idx` is presented. The descriptor outputs follow `desc_sel` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_seed | input | 1 | Retiring load had its value predicted |
| ret_op | input | OPW | Opcode |
| ret_dst | input | RW | Destination register |
| ret_dst_we | input | 1 | Destination register is written |
| ret_src0 | input | RW | First source register |
| ret_use0 | input | 1 | First source is used |
| ret_val0 | input | DW | First source value |
| ret_src1 | input | RW | Second source register |
| ret_use1 | input | 1 | Second source is used |
| ret_val1 | input | DW | Second source value |
| ret_load | input | 1 | Instruction is a load |
| ret_store | input | 1 | Instruction is a store |
| ret_addr | input | AW | Memory address of a load or store |
| conf_valid | input | 1 | A prediction was confirmed correct |
| conf_sid | input | SW | Slice id being released |
| seed_ok | output | 1 | A slice opened on the previous retire |
| seed_sid | output | SW | Id of the slice that opened |
| buf_fill | output | FW | Next buffer write index |
| rd_idx | input | IW | Buffer read index |
| rd_op | output | OPW | Entry opcode |
| rd_dst | output | RW | Entry destination register |
| rd_dst_we | output | 1 | Entry writes its destination |
| rd_live0 | output | 1 | First source is a live-in |
| rd_val0 | output | DW | First live-in value |
| rd_live1 | output | 1 | Second source is a live-in |
| rd_val1 | output | DW | Second live-in value |
| rd_addr | output | AW | Entry memory address |
| rd_load | output | 1 | Entry is a load |
| rd_store | output | 1 | Entry is a store |
| rd_mask | output | NSLICE | Slices the entry belongs to |
| desc_sel | input | SW | Descriptor selected for reading |
| desc_active | output | 1 | Selected slice is active |
| desc_lost | output | 1 | Selected slice cannot be replayed |
| desc_count | output | FW | Entries carrying the selected slice |
| desc_group | output | NSLICE | Slices merged with the selected one |

## Verification
The bench builds the block with eight registers, two slice ids, an eight-entry buffer and a two-entry address table. With two ids, the lack of a free id and the merging of two slices are both reachable. With eight entries, the buffer can be filled completely within a short run. With two table entries, a third store address overflows the table. Every register index is swept as a source, and the bench computes from the register masks it tracks whether each instruction should be captured.

// File: rtl/slc_pkg.sv
package slc_pkg;
  function automatic int low_zero(input logic [31:0] v, input int n);
    int r;
    r = 0;
    for (int i = n - 1; i >= 0; i--) if (!v[i]) r = i;
    return r;
  endfunction
endpackage

// File: rtl/slc_tag_file.sv
module slc_tag_file #(
  parameter int NREG   = 8,
  parameter int NSLICE = 2,
  localparam int RW    = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RW-1:0]     rs0,
  input  logic [RW-1:0]     rs1,
  output logic [NSLICE-1:0] tag0,
  output logic [NSLICE-1:0] tag1,
  input  logic              we,
  input  logic [RW-1:0]     wa,
  input  logic [NSLICE-1:0] wd,
  input  logic [NSLICE-1:0] clr
);
  logic [NSLICE-1:0] tags [NREG];

  assign tag0 = tags[rs0];
  assign tag1 = tags[rs1];

  always_ff @(posedge clk) begin
    for (int r = 0; r < NREG; r++) begin
      if (rst) tags[r] <= '0;
      else if (we && wa == RW'(r)) tags[r] <= wd & ~clr;
      else tags[r] <= tags[r] & ~clr;
    end
  end
endmodule

// File: rtl/slc_addr_table.sv
module slc_addr_table #(
  parameter int NADDR  = 2,
  parameter int AW     = 8,
  parameter int NSLICE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     addr,
  output logic [NSLICE-1:0] hit_mask,
  input  logic              ins_en,
  input  logic [NSLICE-1:0] ins_mask,
  output logic              can_ins,
  input  logic [NSLICE-1:0] clr
);
  logic [AW-1:0]     a_q [NADDR];
  logic [NSLICE-1:0] m_q [NADDR];
  logic [NADDR-1:0]  match, freev, pick;
  logic              found;

  always_comb begin
    hit_mask = '0;
    pick     = '0;
    found    = 1'b0;
    for (int i = 0; i < NADDR; i++) begin
      match[i] = (m_q[i] != '0) && (a_q[i] == addr);
      freev[i] = (m_q[i] == '0);
      if (match[i]) hit_mask = hit_mask | m_q[i];
    end
    if (match != '0) pick = match;
    else begin
      for (int i = 0; i < NADDR; i++) begin
        if (freev[i] && !found) begin
          pick[i] = 1'b1;
          found   = 1'b1;
        end
      end
    end
    can_ins = (pick != '0);
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NADDR; i++) begin
      if (rst) m_q[i] <= '0;
      else if (ins_en && pick[i]) begin
        a_q[i] <= addr;
        m_q[i] <= (m_q[i] | ins_mask) & ~clr;
      end else m_q[i] <= m_q[i] & ~clr;
    end
  end
endmodule

// File: rtl/slc_buffer.sv
module slc_buffer #(
  parameter int DEPTH  = 8,
  parameter int EW     = 32,
  parameter int NSLICE = 2,
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [EW-1:0]     wr_data,
  input  logic [NSLICE-1:0] wr_mask,
  input  logic [NSLICE-1:0] clr,
  input  logic [IW-1:0]     rd_idx,
  output logic [EW-1:0]     rd_data,
  output logic [NSLICE-1:0] rd_mask
);
  logic [EW-1:0]     mem [DEPTH];
  logic [NSLICE-1:0] em  [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    rd_data <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < DEPTH; e++) begin
      if (rst) em[e] <= '0;
      else if (wr_en && wr_idx == IW'(e)) em[e] <= wr_mask & ~clr;
      else em[e] <= em[e] & ~clr;
    end
    if (rst) rd_mask <= '0;
    else rd_mask <= em[rd_idx];
  end
endmodule

// File: rtl/slice_collector.sv
module slice_collector #(
  parameter int NREG   = 8,
  parameter int NSLICE = 2,
  parameter int DEPTH  = 8,
  parameter int NADDR  = 2,
  parameter int DW     = 16,
  parameter int AW     = 8,
  parameter int OPW    = 4,
  localparam int RW    = $clog2(NREG),
  localparam int SW    = (NSLICE > 1) ? $clog2(NSLICE) : 1,
  localparam int IW    = $clog2(DEPTH),
  localparam int FW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ret_valid,
  input  logic              ret_seed,
  input  logic [OPW-1:0]    ret_op,
  input  logic [RW-1:0]     ret_dst,
  input  logic              ret_dst_we,
  input  logic [RW-1:0]     ret_src0,
  input  logic              ret_use0,
  input  logic [DW-1:0]     ret_val0,
  input  logic [RW-1:0]     ret_src1,
  input  logic              ret_use1,
  input  logic [DW-1:0]     ret_val1,
  input  logic              ret_load,
  input  logic              ret_store,
  input  logic [AW-1:0]     ret_addr,
  input  logic              conf_valid,
  input  logic [SW-1:0]     conf_sid,
  output logic              seed_ok,
  output logic [SW-1:0]     seed_sid,
  output logic [FW-1:0]     buf_fill,
  input  logic [IW-1:0]     rd_idx,
  output logic [OPW-1:0]    rd_op,
  output logic [RW-1:0]     rd_dst,
  output logic              rd_dst_we,
  output logic              rd_live0,
  output logic [DW-1:0]     rd_val0,
  output logic              rd_live1,
  output logic [DW-1:0]     rd_val1,
  output logic [AW-1:0]     rd_addr,
  output logic              rd_load,
  output logic              rd_store,
  output logic [NSLICE-1:0] rd_mask,
  input  logic [SW-1:0]     desc_sel,
  output logic              desc_active,
  output logic              desc_lost,
  output logic [FW-1:0]     desc_count,
  output logic [NSLICE-1:0] desc_group
);
  localparam int EW = OPW + RW + 1 + 1 + DW + 1 + DW + AW + 2;

  logic [NSLICE-1:0] tag0, tag1, hit_mask, src_m0, src_m1, mem_m;
  logic [NSLICE-1:0] new_bit, cap_mask, clr, active, act_next;
  logic [SW-1:0]     new_sid;
  logic              any_free, seed_go, capture, full, wr_en, multi;
  logic              tbl_need, can_ins, tbl_fail, li0, li1;
  logic [FW-1:0]     wptr;
  logic [EW-1:0]     wr_data, rd_data;

  logic              d_act  [NSLICE];
  logic              d_lost [NSLICE];
  logic [FW-1:0]     d_cnt  [NSLICE];
  logic [NSLICE-1:0] d_grp  [NSLICE];

  always_comb begin
    for (int s = 0; s < NSLICE; s++) active[s] = d_act[s];
    any_free = (active != {NSLICE{1'b1}});
    new_sid  = SW'(slc_pkg::low_zero(32'(active), NSLICE));
    seed_go  = ret_valid && ret_seed && ret_load && any_free;
    new_bit  = seed_go ? (NSLICE'(1) << new_sid) : '0;
    src_m0   = ret_use0 ? tag0 : '0;
    src_m1   = ret_use1 ? tag1 : '0;
    mem_m    = ret_load ? hit_mask : '0;
    cap_mask = src_m0 | src_m1 | mem_m | new_bit;
    capture  = ret_valid && (cap_mask != '0);
    full     = (wptr == FW'(DEPTH));
    wr_en    = capture && !full;
    multi    = ($countones(cap_mask) > 1);
    tbl_need = capture && ret_store;
    tbl_fail = tbl_need && !can_ins;
    li0      = ret_use0 && (src_m0 == '0);
    li1      = ret_use1 && (src_m1 == '0);
    clr      = conf_valid ? (NSLICE'(1) << conf_sid) : '0;
    act_next = (active | new_bit) & ~clr;
    wr_data  = {ret_op, ret_dst, ret_dst_we, li0, li0 ? ret_val0 : {DW{1'b0}},
                li1, li1 ? ret_val1 : {DW{1'b0}}, ret_addr, ret_load, ret_store};
  end

  slc_tag_file #(.NREG(NREG), .NSLICE(NSLICE)) u_tags (
    .clk(clk), .rst(rst), .rs0(ret_src0), .rs1(ret_src1), .tag0(tag0), .tag1(tag1),
    .we(ret_valid && ret_dst_we), .wa(ret_dst), .wd(capture ? cap_mask : '0), .clr(clr));

  slc_addr_table #(.NADDR(NADDR), .AW(AW), .NSLICE(NSLICE)) u_atab (
    .clk(clk), .rst(rst), .addr(ret_addr), .hit_mask(hit_mask),
    .ins_en(tbl_need && can_ins), .ins_mask(cap_mask), .can_ins(can_ins), .clr(clr));

  slc_buffer #(.DEPTH(DEPTH), .EW(EW), .NSLICE(NSLICE)) u_buf (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wptr[IW-1:0]), .wr_data(wr_data),
    .wr_mask(cap_mask), .clr(clr), .rd_idx(rd_idx), .rd_data(rd_data), .rd_mask(rd_mask));

  assign {rd_op, rd_dst, rd_dst_we, rd_live0, rd_val0, rd_live1, rd_val1,
          rd_addr, rd_load, rd_store} = rd_data;

  generate
    for (genvar s = 0; s < NSLICE; s++) begin : g_desc
      logic hit;
      assign hit = capture && cap_mask[s];
      always_ff @(posedge clk) begin
        if (rst || clr[s]) begin
          d_act[s]  <= 1'b0;
          d_lost[s] <= 1'b0;
          d_cnt[s]  <= '0;
          d_grp[s]  <= '0;
        end else begin
          d_act[s]  <= d_act[s] | new_bit[s];
          d_lost[s] <= (new_bit[s] ? 1'b0 : d_lost[s]) | (hit && (full || tbl_fail));
          d_cnt[s]  <= (new_bit[s] ? '0 : d_cnt[s]) + FW'(hit && !full);
          d_grp[s]  <= (new_bit[s] ? '0 : d_grp[s]) |
                       (hit ? (multi ? cap_mask : (NSLICE'(1) << s)) : '0);
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr     <= '0;
      seed_ok  <= 1'b0;
      seed_sid <= '0;
    end else begin
      if (act_next == '0) wptr <= '0;
      else if (wr_en) wptr <= wptr + FW'(1);
      seed_ok  <= seed_go;
      seed_sid <= new_sid;
    end
  end

  assign buf_fill    = wptr;
  assign desc_active = d_act[desc_sel];
  assign desc_lost   = d_lost[desc_sel];
  assign desc_count  = d_cnt[desc_sel];
  assign desc_group  = d_grp[desc_sel];
endmodule

// File: rtl/slice_collector_chk.sv
module slice_collector_chk #(
  parameter int DEPTH = 8,
  parameter int SW    = 1,
  parameter int FW    = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          conf_valid,
  input logic [SW-1:0] conf_sid,
  input logic [SW-1:0] desc_sel,
  input logic          desc_active,
  input logic          desc_lost,
  input logic [FW-1:0] desc_count,
  input logic [FW-1:0] buf_fill
);
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
    buf_fill <= FW'(DEPTH)); // R8
  AST_FILL_STEP: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (buf_fill == $past(buf_fill)) || (buf_fill == $past(buf_fill) + FW'(1)) ||
             (buf_fill == '0)); // R6
  AST_COUNT_LE_FILL: assert property (@(posedge clk) disable iff (rst)
    desc_count <= buf_fill); // R6
  AST_CONF_RELEASE: assert property (@(posedge clk) disable iff (rst)
    conf_valid |=> (desc_sel != $past(conf_sid)) || !desc_active); // R10
  AST_LOST_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    desc_lost |-> desc_active); // R8
  AST_LOST_STICKY: assert property (@(posedge clk) disable iff (rst)
    (desc_lost && !conf_valid) |=> (desc_sel != $past(desc_sel)) || desc_lost); // R8
endmodule

bind slice_collector slice_collector_chk #(.DEPTH(DEPTH), .SW(SW), .FW(FW)) u_chk (
  .clk(clk), .rst(rst), .conf_valid(conf_valid), .conf_sid(conf_sid), .desc_sel(desc_sel),
  .desc_active(desc_active), .desc_lost(desc_lost), .desc_count(desc_count),
  .buf_fill(buf_fill));

// File: tb/slice_collector_tb.sv
`timescale 1ns/1ps
module slice_collector_tb;
  localparam int NREG = 8, NSLICE = 2, DEPTH = 8, NADDR = 2, DW = 16, AW = 8, OPW = 4;
  localparam int RW = 3, SW = 1, IW = 3, FW = 4;

  logic clk = 0, rst = 1;
  logic ret_valid = 0, ret_seed = 0, ret_dst_we = 0, ret_use0 = 0, ret_use1 = 0;
  logic ret_load = 0, ret_store = 0, conf_valid = 0;
  logic [OPW-1:0] ret_op = '0;
  logic [RW-1:0] ret_dst = '0, ret_src0 = '0, ret_src1 = '0;
  logic [DW-1:0] ret_val0 = '0, ret_val1 = '0;
  logic [AW-1:0] ret_addr = '0;
  logic [SW-1:0] conf_sid = '0, desc_sel = '0;
  logic [IW-1:0] rd_idx = '0;
  logic seed_ok, rd_dst_we, rd_live0, rd_live1, rd_load, rd_store, desc_active, desc_lost;
  logic [SW-1:0] seed_sid;
  logic [FW-1:0] buf_fill, desc_count;
  logic [OPW-1:0] rd_op;
  logic [RW-1:0] rd_dst;
  logic [DW-1:0] rd_val0, rd_val1;
  logic [AW-1:0] rd_addr;
  logic [NSLICE-1:0] rd_mask, desc_group;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  slice_collector #(.NREG(NREG), .NSLICE(NSLICE), .DEPTH(DEPTH), .NADDR(NADDR),
                    .DW(DW), .AW(AW), .OPW(OPW)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic retire(input bit seed, input int op, input int dst, input bit dwe,
                        input int s0, input bit u0, input int v0,
                        input int s1, input bit u1, input int v1,
                        input bit ld, input bit st, input int addr);
    @(negedge clk);
    ret_valid = 1; ret_seed = seed; ret_op = OPW'(op); ret_dst = RW'(dst); ret_dst_we = dwe;
    ret_src0 = RW'(s0); ret_use0 = u0; ret_val0 = DW'(v0);
    ret_src1 = RW'(s1); ret_use1 = u1; ret_val1 = DW'(v1);
    ret_load = ld; ret_store = st; ret_addr = AW'(addr);
    @(posedge clk); #1;
    ret_valid = 0; ret_seed = 0;
  endtask

  task automatic confirm(input int sid);
    @(negedge clk);
    conf_valid = 1; conf_sid = SW'(sid);
    @(posedge clk); #1;
    conf_valid = 0;
  endtask

  task automatic read_entry(input int idx);
    @(negedge clk);
    rd_idx = IW'(idx);
    @(posedge clk); #1;
  endtask

  task automatic sel_desc(input int s);
    desc_sel = SW'(s); #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int fill;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1: reset state
    chk_eq("R1 reset fill", int'(buf_fill), 0);
    chk_eq("R1 reset seed_ok", int'(seed_ok), 0);
    sel_desc(0); chk_eq("R1 reset desc0 active", int'(desc_active), 0);

    // R1/R5: seed load r1 <- [0x40], base r2 untagged = 0x1234
    retire(1, 1, 1, 1, 2, 1, 'h1234, 0, 0, 0, 1, 0, 'h40);
    chk_eq("R1 seed_ok", int'(seed_ok), 1);
    chk_eq("R1 seed_sid", int'(seed_sid), 0);
    chk_eq("R6 fill after seed", int'(buf_fill), 1);
    sel_desc(0);
    chk_eq("R1 desc active", int'(desc_active), 1);
    chk_eq("R1 desc group", int'(desc_group), 1);
    read_entry(0);
    chk_eq("R1 seed entry mask", int'(rd_mask), 1);
    chk_eq("R5 seed live0", int'(rd_live0), 1);
    chk_eq("R5 seed val0", int'(rd_val0), 'h1234);
    chk_eq("R11 seed addr", int'(rd_addr), 'h40);

    // R2/R5: r3 = r1 + r4 (r4 untagged = 7)
    retire(0, 2, 3, 1, 1, 1, 'h55, 4, 1, 7, 0, 0, 0);
    chk_eq("R2 fill after add", int'(buf_fill), 2);
    read_entry(1);
    chk_eq("R5 tagged src not live", int'(rd_live0), 0);
    chk_eq("R5 untagged src live", int'(rd_live1), 1);
    chk_eq("R5 live1 value", int'(rd_val1), 7);
    chk_eq("R11 op", int'(rd_op), 2);
    chk_eq("R11 dst", int'(rd_dst), 3);
    // R11: changing rd_idx leaves output until next edge
    @(negedge clk); rd_idx = 0; #1;
    chk_eq("R11 read latency", int'(rd_op), 2);

    // R2: sweep all registers as a lone source; r1 and r3 are tagged
    fill = 2;
    for (int r = 0; r < NREG; r++) begin
      retire(0, 5, 0, 0, r, 1, 'h100 + r, 0, 0, 0, 0, 0, 0);
      if (r == 1 || r == 3) fill++;
      chk_eq($sformatf("R2 sweep r%0d fill", r), int'(buf_fill), fill);
    end
    read_entry(3);
    chk_eq("R6 order entry3 is r3 use", int'(rd_op), 5);
    chk_eq("R5 tagged sweep src not live", int'(rd_live0), 0);

    // R3: r3 overwritten from untagged r5, then read
    retire(0, 6, 3, 1, 5, 1, 9, 0, 0, 0, 0, 0, 0);
    chk_eq("R3 overwrite not captured", int'(buf_fill), 4);
    retire(0, 6, 0, 0, 3, 1, 9, 0, 0, 0, 0, 0, 0);
    chk_eq("R3 cleared reg not captured", int'(buf_fill), 4);

    // R4: store r1 data to 0x80, load 0x80 -> r6, load 0x81
    retire(0, 7, 0, 0, 1, 1, 0, 0, 0, 0, 0, 1, 'h80);
    chk_eq("R4 slice store captured", int'(buf_fill), 5);
    retire(0, 8, 6, 1, 0, 0, 0, 0, 0, 0, 1, 0, 'h80);
    chk_eq("R4 dependent load captured", int'(buf_fill), 6);
    retire(0, 8, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 'h81);
    chk_eq("R4 other address not captured", int'(buf_fill), 6);
    read_entry(5);
    chk_eq("R4 load entry mask", int'(rd_mask), 1);

    // R7: second slice from load r2, then r5 = r2 + r6
    retire(1, 1, 2, 1, 0, 0, 0, 0, 0, 0, 1, 0, 'h50);
    chk_eq("R1 second seed id", int'(seed_sid), 1);
    retire(0, 9, 5, 1, 2, 1, 0, 6, 1, 0, 0, 0, 0);
    chk_eq("R7 fill after merge", int'(buf_fill), 8);
    read_entry(7);
    chk_eq("R7 merged entry mask", int'(rd_mask), 3);
    sel_desc(0);
    chk_eq("R7 desc0 group", int'(desc_group), 3);
    chk_eq("R6 desc0 count", int'(desc_count), 7);
    sel_desc(1);
    chk_eq("R7 desc1 group", int'(desc_group), 3);
    chk_eq("R6 desc1 count", int'(desc_count), 2);

    // R8: buffer full, slice 0 consumer
    retire(0, 10, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0);
    chk_eq("R8 fill held", int'(buf_fill), 8);
    sel_desc(0); chk_eq("R8 slice0 lost", int'(desc_lost), 1);
    chk_eq("R8 count held", int'(desc_count), 7);
    sel_desc(1); chk_eq("R8 slice1 not lost", int'(desc_lost), 0);

    // R1: no free id
    retire(1, 1, 4, 1, 0, 0, 0, 0, 0, 0, 1, 0, 'h60);
    chk_eq("R1 no free id", int'(seed_ok), 0);

    // R10: release both
    confirm(0);
    sel_desc(0);
    chk_eq("R10 desc0 inactive", int'(desc_active), 0);
    chk_eq("R10 desc0 count", int'(desc_count), 0);
    chk_eq("R10 desc0 lost", int'(desc_lost), 0);
    chk_eq("R10 fill kept while slice1 active", int'(buf_fill), 8);
    read_entry(7);
    chk_eq("R10 entry bit removed", int'(rd_mask), 2);
    confirm(1);
    chk_eq("R10 fill reset", int'(buf_fill), 0);
    retire(0, 10, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0);
    chk_eq("R10 tag cleared", int'(buf_fill), 0);
    retire(0, 8, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 'h80);
    chk_eq("R10 table cleared", int'(buf_fill), 0);

    // R9: address table overflow
    retire(1, 1, 1, 1, 0, 0, 0, 0, 0, 0, 1, 0, 'h10);
    chk_eq("R1 reuse id 0", int'(seed_sid), 0);
    retire(0, 7, 0, 0, 1, 1, 0, 0, 0, 0, 0, 1, 'h20);
    retire(0, 7, 0, 0, 1, 1, 0, 0, 0, 0, 0, 1, 'h30);
    sel_desc(0); chk_eq("R9 not lost with two addresses", int'(desc_lost), 0);
    retire(0, 7, 0, 0, 1, 1, 0, 0, 0, 0, 0, 1, 'h20);
    sel_desc(0); chk_eq("R9 repeat address fits", int'(desc_lost), 0);
    retire(0, 7, 0, 0, 1, 1, 0, 0, 0, 0, 0, 1, 'h40);
    sel_desc(0); chk_eq("R9 table overflow lost", int'(desc_lost), 1);
    chk_eq("R9 entry still written", int'(buf_fill), 5);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule